// File: doc/BRIEF.md
# Interrupt Arbitration and Exception-Entry Sequencer

This block sits next to a 32-bit processor core. It decides at each instruction boundary whether a pending interrupt may be taken. It weighs an external prioritized level request against one latched internal peripheral request. When a request is accepted, the block runs the exception entry on its own memory port:
- it stacks the status word and the return address;
- it raises the interrupt mask to the accepted level;
- it loads the handler address from the vector table.

After reset the same port fetches the starting program counter and stack pointer.

The core supplies its current status word, program counter, stack pointer and vector base. The block returns write strobes with new values for those registers. The core must hold off issuing instructions while `busy_o` is high. Memory uses a valid/ready handshake with one access in flight at a time.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only when its level is strictly greater than the mask field, status bits [7:4]. A request at or below the mask is not taken and stays pending, so it can be taken later once the mask is lowered.
- R2: If both sources are pending, the external level wins only when it is strictly greater than the internal level. On a tie, or when the internal level is greater, the internal request and its supplied vector are used. An external level of 0 means no external request.
- R3: An accepted external request uses vector number 64 + level/2, with integer division.
- R4: Entry writes the status word to address SP-4, then writes the return PC (the `pc_i` value at acceptance) to SP-8. After each write the stack pointer output is updated, to SP-4 and then to SP-8.
- R5: After the pushes, status bits [7:4] take the accepted level. Every other status bit keeps the value it had at acceptance.
- R6: The new PC is the 32-bit word read from vector base + 4 × vector number.
- R7: No request is taken while `delay_slot_i` is high. It can be taken at a later boundary where `delay_slot_i` is low.
- R8: `busy_o` stays high for at least 13 clocks per accepted interrupt. It is exactly 13 clocks when memory answers in the same cycle.
- R9: An accepted internal request clears its own pending flag. An internal request that loses or is masked stays pending. An external level stays pending for as long as the requester drives it.
- R10: On acceptance, `ack_o` is high for exactly one cycle, the cycle after the accepting edge. In that cycle `ack_level_o` carries the accepted level.
- R11: After reset, the PC is loaded from the word at address 0 and the SP from the word at address 4. Status bits [7:4] are then set to 1111 and the other status bits are kept.
- R12: A memory request keeps `mem_valid_o` high and `mem_addr_o` stable until `mem_ready_i` is seen. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| delay_slot_i | input | 1 | A branch delay slot instruction is still pending |
| ext_level_i | input | 4 | External request level, 0 = none |
| int_set_i | input | 1 | Latch a new internal request |
| int_level_i | input | 4 | Level of the internal request being latched |
| int_vector_i | input | 8 | Vector number of the internal request being latched |
| sr_i | input | 32 | Core status word |
| pc_i | input | 32 | Return address offered by the core |
| sp_i | input | 32 | Core stack pointer (R15) |
| vbr_i | input | 32 | Vector table base |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepted or completed the access |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| busy_o | output | 1 | Sequencer is running; the core must stall |
| ack_o | output | 1 | One-cycle acceptance pulse |
| ack_level_o | output | 4 | Level of the accepted request |
| pc_we_o | output | 1 | Write strobe for the core PC |
| pc_o | output | 32 | New PC |
| sp_we_o | output | 1 | Write strobe for the core SP |
| sp_o | output | 32 | New SP |
| sr_we_o | output | 1 | Write strobe for the core status word |
| sr_o | output | 32 | New status word |

## Verification
With single-cycle memory, each result has a fixed due time:
- `ack_o` and `busy_o` appear in the cycle after the clock edge that sees `boundary_i`.
- The handler PC, the stack pointer and the raised mask are all written by the time `busy_o` falls, exactly 13 cycles after the accepting edge.
- After reset the two fetches finish in two cycles.

The bench plays the core: it holds the register file, which it updates from the write strobes. It samples one time unit after each rising edge, so it counts busy cycles exactly and reads acknowledge in its single valid cycle. A wait-state run stretches the handshake. There, only the final register values and the lower bound on busy length are checked, together with the stability of pending requests.

// File: rtl/irq_pkg.sv
// Package: shared state encoding for the interrupt entry sequencer.
// Assumes: one sequencer per core; states are private to the block.
package irq_pkg;
    typedef enum logic [2:0] {
        S_RST_PC,
        S_RST_SP,
        S_IDLE,
        S_PUSH_SR,
        S_PUSH_PC,
        S_FETCH,
        S_HOLD
    } seq_st_t;
endpackage

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Holds the single internal request and picks between it and the external
// level. Produces the winning level and vector, and whether the level
// clears the current mask.
// Assumes: external level 0 means none; take_i is high only when the
// sequencer accepts the current selection.
module irq_arbiter #(
    parameter int LVL_W    = 4,
    parameter int VEC_W    = 8,
    parameter int EXT_BASE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ext_level_i,
    input  logic             int_set_i,
    input  logic [LVL_W-1:0] int_level_i,
    input  logic [VEC_W-1:0] int_vector_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             take_i,
    output logic             sel_valid_o,
    output logic             sel_ext_o,
    output logic [LVL_W-1:0] sel_level_o,
    output logic [VEC_W-1:0] sel_vector_o
);
    logic             int_pend;
    logic [LVL_W-1:0] int_lvl_q;
    logic [VEC_W-1:0] int_vec_q;
    logic [LVL_W-1:0] pend_lvl;
    logic [VEC_W-1:0] ext_vec;

    // Latch a new internal request; clear it when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend  <= 1'b0;
            int_lvl_q <= '0;
            int_vec_q <= '0;
        end else if (int_set_i) begin
            int_pend  <= 1'b1;
            int_lvl_q <= int_level_i;
            int_vec_q <= int_vector_i;
        end else if (take_i && !sel_ext_o) begin
            int_pend  <= 1'b0;
        end
    end

    // Select the winner: external only when strictly higher.
    always_comb begin
        pend_lvl     = int_pend ? int_lvl_q : '0;
        ext_vec      = VEC_W'(EXT_BASE) + VEC_W'(ext_level_i >> 1);
        sel_ext_o    = ext_level_i > pend_lvl;
        sel_level_o  = sel_ext_o ? ext_level_i : pend_lvl;
        sel_vector_o = sel_ext_o ? ext_vec : int_vec_q;
        sel_valid_o  = sel_level_o > mask_i;
    end

    AST_INT_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !sel_ext_o && !int_set_i) |=> !int_pend); // R9
    AST_INT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pend && !take_i && !int_set_i) |=> int_pend); // R9
endmodule

// File: rtl/irq_entry_fsm.sv
// Module: irq_entry_fsm
// Runs the reset fetch and the interrupt entry on a single-outstanding
// valid/ready memory port. Stretches each entry to a minimum busy length.
// Assumes: the core applies the pc/sp/sr strobes on the same edge and
// stalls while busy_o is high.
module irq_entry_fsm
    import irq_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int LVL_W    = 4,
    parameter int VEC_W    = 8,
    parameter int MASK_LSB = 4,
    parameter int MIN_BUSY = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             delay_slot_i,
    input  logic             sel_valid_i,
    input  logic [LVL_W-1:0] sel_level_i,
    input  logic [VEC_W-1:0] sel_vector_i,
    input  logic [XLEN-1:0]  sr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  sp_i,
    input  logic [XLEN-1:0]  vbr_i,
    output logic             mem_valid_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    input  logic             mem_ready_i,
    input  logic [XLEN-1:0]  mem_rdata_i,
    output logic             take_o,
    output logic             busy_o,
    output logic             ack_o,
    output logic [LVL_W-1:0] ack_level_o,
    output logic             pc_we_o,
    output logic [XLEN-1:0]  pc_o,
    output logic             sp_we_o,
    output logic [XLEN-1:0]  sp_o,
    output logic             sr_we_o,
    output logic [XLEN-1:0]  sr_o
);
    localparam int CNT_W = $clog2(MIN_BUSY + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MIN_BUSY - 1);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    seq_st_t          st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic [XLEN-1:0]  sp_q, sr_q, pc_q;
    logic             done_min;

    assign take_o   = (st == S_IDLE) && boundary_i && !delay_slot_i && sel_valid_i;
    assign busy_o   = (st != S_IDLE);
    assign done_min = (cnt >= CNT_END);

    // State register, busy counter and context captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_RST_PC;
            cnt         <= '0;
            lvl_q       <= '0;
            vec_q       <= '0;
            sp_q        <= '0;
            sr_q        <= '0;
            pc_q        <= '0;
            ack_o       <= 1'b0;
            ack_level_o <= '0;
        end else begin
            st          <= st_nx;
            ack_o       <= take_o;
            ack_level_o <= take_o ? sel_level_i : ack_level_o;
            if (take_o) begin
                cnt   <= '0;
                lvl_q <= sel_level_i;
                vec_q <= sel_vector_i;
                sp_q  <= sp_i;
                sr_q  <= sr_i;
                pc_q  <= pc_i;
            end else if (busy_o && cnt != {CNT_W{1'b1}}) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Per-state memory request, register strobes and next state.
    always_comb begin
        st_nx       = st;
        mem_valid_o = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        pc_we_o     = 1'b0;
        pc_o        = mem_rdata_i;
        sp_we_o     = 1'b0;
        sp_o        = mem_rdata_i;
        sr_we_o     = 1'b0;
        sr_o        = sr_i;
        unique case (st)
            S_RST_PC: begin
                mem_valid_o = 1'b1;
                pc_we_o     = mem_ready_i;
                if (mem_ready_i) st_nx = S_RST_SP;
            end
            S_RST_SP: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = WORD;
                sp_we_o     = mem_ready_i;
                sr_we_o     = mem_ready_i;
                sr_o[MASK_LSB +: LVL_W] = '1;
                if (mem_ready_i) st_nx = S_IDLE;
            end
            S_IDLE: begin
                if (take_o) st_nx = S_PUSH_SR;
            end
            S_PUSH_SR: begin
                mem_valid_o = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - WORD;
                mem_wdata_o = sr_q;
                sp_we_o     = mem_ready_i;
                sp_o        = sp_q - WORD;
                if (mem_ready_i) st_nx = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_valid_o = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - (WORD << 1);
                mem_wdata_o = pc_q;
                sp_we_o     = mem_ready_i;
                sp_o        = sp_q - (WORD << 1);
                sr_we_o     = mem_ready_i;
                sr_o        = sr_q;
                sr_o[MASK_LSB +: LVL_W] = lvl_q;
                if (mem_ready_i) st_nx = S_FETCH;
            end
            S_FETCH: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = vbr_i + {{(XLEN-VEC_W-2){1'b0}}, vec_q, 2'b00};
                pc_we_o     = mem_ready_i;
                if (mem_ready_i) st_nx = done_min ? S_IDLE : S_HOLD;
            end
            S_HOLD: begin
                if (done_min) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    AST_MASK_GT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (ack_level_o > $past(sr_i[MASK_LSB +: LVL_W]))); // R1
    AST_DS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && delay_slot_i) |=> !ack_o); // R7
    AST_BUSY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && ($past(st) == S_FETCH || $past(st) == S_HOLD))
            |-> ($past(cnt) >= CNT_END)); // R8
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o))); // R12
endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Joins the request arbiter and the entry sequencer. The mask compared
// against requests is taken from the core status word.
// Assumes: 32-bit core registers; reset is synchronous and active low.
module irq_entry_seq #(
    parameter int XLEN     = 32,
    parameter int LVL_W    = 4,
    parameter int VEC_W    = 8,
    parameter int MASK_LSB = 4,
    parameter int EXT_BASE = 64,
    parameter int MIN_BUSY = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             delay_slot_i,
    input  logic [LVL_W-1:0] ext_level_i,
    input  logic             int_set_i,
    input  logic [LVL_W-1:0] int_level_i,
    input  logic [VEC_W-1:0] int_vector_i,
    input  logic [XLEN-1:0]  sr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  sp_i,
    input  logic [XLEN-1:0]  vbr_i,
    output logic             mem_valid_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    input  logic             mem_ready_i,
    input  logic [XLEN-1:0]  mem_rdata_i,
    output logic             busy_o,
    output logic             ack_o,
    output logic [LVL_W-1:0] ack_level_o,
    output logic             pc_we_o,
    output logic [XLEN-1:0]  pc_o,
    output logic             sp_we_o,
    output logic [XLEN-1:0]  sp_o,
    output logic             sr_we_o,
    output logic [XLEN-1:0]  sr_o
);
    logic             take;
    logic             sel_valid;
    logic             sel_ext;
    logic [LVL_W-1:0] sel_level;
    logic [VEC_W-1:0] sel_vector;

    irq_arbiter #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .EXT_BASE(EXT_BASE)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .ext_level_i(ext_level_i),
        .int_set_i(int_set_i), .int_level_i(int_level_i), .int_vector_i(int_vector_i),
        .mask_i(sr_i[MASK_LSB +: LVL_W]),
        .take_i(take),
        .sel_valid_o(sel_valid), .sel_ext_o(sel_ext),
        .sel_level_o(sel_level), .sel_vector_o(sel_vector)
    );

    irq_entry_fsm #(
        .XLEN(XLEN), .LVL_W(LVL_W), .VEC_W(VEC_W),
        .MASK_LSB(MASK_LSB), .MIN_BUSY(MIN_BUSY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .boundary_i(boundary_i), .delay_slot_i(delay_slot_i),
        .sel_valid_i(sel_valid), .sel_level_i(sel_level), .sel_vector_i(sel_vector),
        .sr_i(sr_i), .pc_i(pc_i), .sp_i(sp_i), .vbr_i(vbr_i),
        .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .take_o(take), .busy_o(busy_o),
        .ack_o(ack_o), .ack_level_o(ack_level_o),
        .pc_we_o(pc_we_o), .pc_o(pc_o),
        .sp_we_o(sp_we_o), .sp_o(sp_o),
        .sr_we_o(sr_we_o), .sr_o(sr_o)
    );
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    localparam logic [31:0] VBR     = 32'h100;
    localparam logic [31:0] SP0     = 32'h3F0;
    localparam logic [31:0] PC_RET  = 32'h0000_1234;
    localparam logic [31:0] SR_BASE = 32'h0000_0301;
    localparam int NV = 10;
    // fields: mask, ext, int level (0 = no set), int vec, exp ack, exp level, exp vec
    localparam logic [NV-1:0][32:0] VEC = {
        {4'd2,  4'd0,  4'd10, 8'h12, 1'b1, 4'd10, 8'h12},
        {4'd15, 4'd15, 4'd0,  8'h00, 1'b0, 4'd0,  8'h00},
        {4'd14, 4'd15, 4'd0,  8'h00, 1'b1, 4'd15, 8'd71},
        {4'd0,  4'd1,  4'd0,  8'h00, 1'b1, 4'd1,  8'd64},
        {4'd0,  4'd0,  4'd0,  8'h00, 1'b1, 4'd6,  8'h21},
        {4'd0,  4'd7,  4'd6,  8'h21, 1'b1, 4'd7,  8'd67},
        {4'd0,  4'd6,  4'd6,  8'h20, 1'b1, 4'd6,  8'h20},
        {4'd3,  4'd4,  4'd0,  8'h00, 1'b1, 4'd4,  8'd66},
        {4'd3,  4'd3,  4'd0,  8'h00, 1'b0, 4'd0,  8'h00},
        {4'd0,  4'd5,  4'd0,  8'h00, 1'b1, 4'd5,  8'd66}
    };

    logic clk = 0, rst_n = 0;
    logic boundary = 0, ds = 0, int_set = 0;
    logic [3:0] ext_lvl = 0, int_lvl = 0, ack_level;
    logic [7:0] int_vec = 0;
    logic [31:0] core_pc = 0, core_sp = 0, core_sr = SR_BASE;
    logic mem_valid, mem_we, mem_ready, busy, ack, pc_we, sp_we, sr_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_o, sp_o, sr_o;
    logic [31:0] mem [0:255];
    logic ws_mode = 0, ws_tog = 0, prev_wait = 0;
    logic [31:0] prev_addr = 0;
    int total = 0, bad = 0, hold_err = 0;

    always #2 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .delay_slot_i(ds),
        .ext_level_i(ext_lvl), .int_set_i(int_set), .int_level_i(int_lvl),
        .int_vector_i(int_vec), .sr_i(core_sr), .pc_i(PC_RET), .sp_i(core_sp),
        .vbr_i(VBR), .mem_valid_o(mem_valid), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .ack_o(ack), .ack_level_o(ack_level),
        .pc_we_o(pc_we), .pc_o(pc_o), .sp_we_o(sp_we), .sp_o(sp_o),
        .sr_we_o(sr_we), .sr_o(sr_o)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_ready = mem_valid && (!ws_mode || ws_tog);

    // Memory, core register file and request-hold monitor.
    always @(posedge clk) begin
        ws_tog <= ~ws_tog;
        if (mem_valid && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
        if (pc_we) core_pc <= pc_o;
        if (sp_we) core_sp <= sp_o;
        if (sr_we) core_sr <= sr_o;
        if (rst_n) begin
            if (prev_wait && (!mem_valid || mem_addr != prev_addr)) hold_err <= hold_err + 1;
            prev_wait <= mem_valid && !mem_ready;
            prev_addr <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_irq(input logic [3:0] mask, input logic [3:0] ext, input logic [3:0] il,
                          input logic [7:0] iv, input bit dsl, input bit exp_ack,
                          input logic [3:0] exp_lvl, input logic [7:0] exp_vec, input string req);
        int n;
        @(negedge clk);
        core_sr = SR_BASE | (32'(mask) << 4);
        core_sp = SP0;
        core_pc = 32'h0;
        ext_lvl = ext;
        if (il != 0) begin
            int_set = 1; int_lvl = il; int_vec = iv;
        end
        @(negedge clk);
        int_set = 0; boundary = 1; ds = dsl;
        @(posedge clk); #1;
        boundary = 0; ds = 0;
        chk(ack == exp_ack, {req, " ack"}, 32'(ack), 32'(exp_ack));
        if (exp_ack) begin
            chk(ack_level == exp_lvl, {req, " R10 ack level"}, 32'(ack_level), 32'(exp_lvl));
            n = 1;
            for (int k = 0; k < 200; k++) begin
                @(posedge clk); #1;
                if (k == 0) chk(ack == 0, {req, " R10 one-cycle ack"}, 32'(ack), 0);
                if (!busy) break;
                n++;
            end
            if (ws_mode) chk(n >= 13, {req, " R8 busy min"}, n, 13);
            else chk(n == 13, {req, " R8 busy length"}, n, 13);
            chk(core_pc == mem[(VBR + 4 * 32'(exp_vec)) >> 2], {req, " R6 new pc"},
                core_pc, mem[(VBR + 4 * 32'(exp_vec)) >> 2]);
            chk(core_sp == SP0 - 8, {req, " R4 sp"}, core_sp, SP0 - 8);
            chk(mem[(SP0 - 4) >> 2] == (SR_BASE | (32'(mask) << 4)), {req, " R4 pushed sr"},
                mem[(SP0 - 4) >> 2], SR_BASE | (32'(mask) << 4));
            chk(mem[(SP0 - 8) >> 2] == PC_RET, {req, " R4 pushed pc"}, mem[(SP0 - 8) >> 2], PC_RET);
            chk(core_sr == (SR_BASE | (32'(exp_lvl) << 4)), {req, " R5 new sr"},
                core_sr, SR_BASE | (32'(exp_lvl) << 4));
        end else begin
            chk(busy == 0, {req, " idle when not taken"}, 32'(busy), 0);
        end
        @(negedge clk);
        ext_lvl = 0;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
        mem[1] = SP0;
        repeat (3) @(negedge clk);
        chk(ack == 0, "R10 ack low in reset", 32'(ack), 0);
        rst_n = 1;
        #1;
        chk(mem_valid && !mem_we && mem_addr == 0, "R11 first fetch at 0", mem_addr, 0);
        for (int k = 0; k < 20 && busy; k++) @(negedge clk);
        chk(core_pc == 32'hA000_0000, "R11 reset pc", core_pc, 32'hA000_0000);
        chk(core_sp == SP0, "R11 reset sp", core_sp, SP0);
        chk(core_sr == 32'h0000_03F1, "R11 reset sr mask", core_sr, 32'h0000_03F1);

        for (int i = 0; i < NV; i++)
            do_irq(VEC[i][32:29], VEC[i][28:25], VEC[i][24:21], VEC[i][20:13], 1'b0,
                   VEC[i][12], VEC[i][11:8], VEC[i][7:0], $sformatf("R1 R2 R3 table %0d", i));

        // R7: delay slot blocks, later boundary takes it
        do_irq(4'd0, 4'd5, 4'd0, 8'h0, 1'b1, 1'b0, 4'd0, 8'd0, "R7 delay slot blocked");
        do_irq(4'd0, 4'd5, 4'd0, 8'h0, 1'b0, 1'b1, 4'd5, 8'd66, "R7 taken after slot");
        // R9: internal clears itself
        do_irq(4'd0, 4'd0, 4'd3, 8'h15, 1'b0, 1'b1, 4'd3, 8'h15, "R9 internal taken");
        do_irq(4'd0, 4'd0, 4'd0, 8'h0, 1'b0, 1'b0, 4'd0, 8'd0, "R9 internal auto-cleared");
        // R9: external persists while driven
        do_irq(4'd0, 4'd9, 4'd0, 8'h0, 1'b0, 1'b1, 4'd9, 8'd68, "R9 external first");
        do_irq(4'd0, 4'd9, 4'd0, 8'h0, 1'b0, 1'b1, 4'd9, 8'd68, "R9 external again");
        // R1: masked internal stays pending, taken once mask drops
        do_irq(4'd5, 4'd0, 4'd3, 8'h16, 1'b0, 1'b0, 4'd0, 8'd0, "R1 internal masked");
        do_irq(4'd0, 4'd0, 4'd0, 8'h0, 1'b0, 1'b1, 4'd3, 8'h16, "R1 R9 masked one later");
        // R12/R8: wait-state memory
        ws_mode = 1;
        do_irq(4'd1, 4'd12, 4'd0, 8'h0, 1'b0, 1'b1, 4'd12, 8'd70, "R12 wait states");
        ws_mode = 0;
        chk(hold_err == 0, "R12 request held until ready", hold_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule